// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is the multiply-accumulate stage of a DSP datapath. In one clock it picks two 16-bit operands, widens each to 17 bits as signed or unsigned, multiplies them and adds the 34-bit product to a 40-bit accumulator value. In the same clock it can double the product for fractional (Q15) arithmetic, round the sum to a 16-bit boundary, flag a zero result and flag or saturate a result that leaves the 32-bit signed range. The result and both flags are registered, so they appear one clock after the operands.

The first operand comes from a 16-bit temporary register inside the block, from a data input or from bits 31:16 of the accumulator input. The second operand comes from a program input, from the data input or from the same accumulator word. The accumulator input is also the addend. The accumulator registers, memories and instruction decode live outside this block.

Top module: `fmac_unit`

## Requirements
- R1: One clock after the operands are applied, `res_o` equals `acc_i` plus the product of the two selected 17-bit operands, taken modulo 2^40, when no mode is enabled.
- R2: An operand whose signed control is 1 is widened by copying its bit 15. An operand whose signed control is 0 is widened with a 0 bit.
- R3: `xsel_i` code 0 selects the temporary register, code 1 selects `data_i`, and codes 2 and 3 select `acc_i[31:16]`. `ysel_i` code 0 selects `prog_i`, code 1 selects `data_i`, and codes 2 and 3 select `acc_i[31:16]`.
- R4: With `frac_i` = 1 the product is doubled before it is added.
- R5: With `rnd_i` = 1, 0x8000 is added to the exact sum and bits 15:0 are then cleared. A rounded result that is not saturated has bits 15:0 equal to zero.
- R6: `zero_o` is 1 exactly when the registered `res_o` is all zeros.
- R7: `ovf_o` is 1 when the exact (rounded) sum lies outside the range -2^31 to 2^31-1, and 0 otherwise.
- R8: With `sat_i` = 1 and an overflow, `res_o` is 0x007FFFFFFF for a positive exact sum and 0xFF80000000 for a negative one. With `sat_i` = 0 the exact sum is kept modulo 2^40.
- R9: The temporary register loads `tdin_i` at a clock edge where `tld_i` = 1 and holds its value otherwise. An operation in the cycle of a load uses the value held before that edge.
- R10: While `rst_n` is low, `res_o` is 0, `zero_o` is 1, `ovf_o` is 0 and the temporary register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tld_i | input | 1 | Load strobe for the temporary register |
| tdin_i | input | 16 | Value to load into the temporary register |
| data_i | input | 16 | Data operand |
| prog_i | input | 16 | Program operand |
| acc_i | input | 40 | Addend, and source of the accumulator-word operand |
| xsel_i | input | 2 | First operand select |
| ysel_i | input | 2 | Second operand select |
| xsgn_i | input | 1 | First operand is signed |
| ysgn_i | input | 1 | Second operand is signed |
| frac_i | input | 1 | Fractional mode: double the product |
| rnd_i | input | 1 | Round the sum |
| sat_i | input | 1 | Saturate on overflow |
| res_o | output | 40 | Registered result |
| zero_o | output | 1 | Registered zero flag |
| ovf_o | output | 1 | Registered overflow flag |

## Verification
Rounding and saturation can act in the same cycle: the rounding carry alone can push a sum past 2^31-1. The bench sets this up with an addend of 0x7FFF8000, a zero product and both rounding and saturation enabled. It expects the overflow flag set and the positive clamp value, not a rounded 0x0080000000. A second case pairs the fractional doubling with saturation on a negative sum, and a pseudo-random run compares every mode combination against an arithmetic model in the bench.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
   // first operand sources
   localparam logic [1:0] XSRC_TREG = 2'd0;
   localparam logic [1:0] XSRC_DATA = 2'd1;
   // second operand sources
   localparam logic [1:0] YSRC_PROG = 2'd0;
   localparam logic [1:0] YSRC_DATA = 2'd1;
   // code 2 and 3 of either select: upper accumulator word

   typedef struct packed {
      logic frac;
      logic rnd;
      logic sat;
   } fmac_mode_t;
endpackage

// File: rtl/fmac_opsel.sv
module fmac_opsel #(
   parameter int DW = 16
) (
   input  logic [1:0]  sel_i,
   input  logic [DW-1:0] prim_i,
   input  logic [DW-1:0] data_i,
   input  logic [DW-1:0] accw_i,
   input  logic        sgn_i,
   output logic [DW:0] op_o
);
   logic [DW-1:0] pick;

   always_comb begin
      unique case (sel_i)
         2'd0:    pick = prim_i;
         2'd1:    pick = data_i;
         default: pick = accw_i;
      endcase
      op_o = {sgn_i & pick[DW-1], pick};
   end
endmodule

// File: rtl/fmac_core.sv
module fmac_core
   import fmac_pkg::*;
#(
   parameter int DW    = 16,
   parameter int AW    = 40,
   parameter int SAT_W = 32
) (
   input  logic [DW:0]   x_i,
   input  logic [DW:0]   y_i,
   input  logic [AW-1:0] acc_i,
   input  fmac_mode_t    mode_i,
   output logic [AW-1:0] res_o,
   output logic          zero_o,
   output logic          ovf_o
);
   localparam int PW = 2 * (DW + 1);
   localparam int EW = AW + 2;
   localparam int HW = EW - SAT_W + 1;
   localparam logic [EW-1:0] RND_ADD  = EW'(1) << (DW - 1);
   localparam logic [EW-1:0] LOW_MASK = (EW'(1) << DW) - EW'(1);
   localparam logic [AW-1:0] POS_LIM  = {{(AW-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
   localparam logic [AW-1:0] NEG_LIM  = {{(AW-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

   logic signed [PW-1:0] prod;
   logic [EW-1:0] prod_e, acc_e, sum, rsum;
   logic [HW-1:0] hi;

   always_comb begin
      prod   = $signed(x_i) * $signed(y_i);
      prod_e = {{(EW-PW){prod[PW-1]}}, prod};
      if (mode_i.frac) prod_e = prod_e << 1;
      acc_e  = {{(EW-AW){acc_i[AW-1]}}, acc_i};
      sum    = acc_e + prod_e;
      rsum   = mode_i.rnd ? ((sum + RND_ADD) & ~LOW_MASK) : sum;
      hi     = rsum[EW-1:SAT_W-1];
      ovf_o  = !((&hi) || !(|hi));
      if (mode_i.sat && ovf_o)
         res_o = rsum[EW-1] ? NEG_LIM : POS_LIM;
      else
         res_o = rsum[AW-1:0];
      zero_o = (res_o == '0);
   end
endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
   import fmac_pkg::*;
#(
   parameter int DW    = 16,
   parameter int AW    = 40,
   parameter int SAT_W = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tld_i,
   input  logic [15:0]   tdin_i,
   input  logic [15:0]   data_i,
   input  logic [15:0]   prog_i,
   input  logic [39:0]   acc_i,
   input  logic [1:0]    xsel_i,
   input  logic [1:0]    ysel_i,
   input  logic          xsgn_i,
   input  logic          ysgn_i,
   input  logic          frac_i,
   input  logic          rnd_i,
   input  logic          sat_i,
   output logic [39:0]   res_o,
   output logic          zero_o,
   output logic          ovf_o
);
   localparam int NOPS = 2;

   if (DW != 16 || AW != 40) begin : g_bad_port_width
      $error("fmac_unit: port widths fixed at DW=16 AW=40");
   end
   if (SAT_W <= DW || SAT_W >= AW) begin : g_bad_sat_width
      $error("fmac_unit: SAT_W must lie between DW and AW");
   end
   if (2 * DW > AW - 8) begin : g_bad_guard
      $error("fmac_unit: accumulator needs room for the accumulator word");
   end

   logic [DW-1:0] t_q;
   logic [DW-1:0] prim [NOPS];
   logic [1:0]    sel  [NOPS];
   logic          sgn  [NOPS];
   logic [DW:0]   op   [NOPS];

   assign prim[0] = t_q;
   assign prim[1] = prog_i;
   assign sel[0]  = xsel_i;
   assign sel[1]  = ysel_i;
   assign sgn[0]  = xsgn_i;
   assign sgn[1]  = ysgn_i;

   for (genvar gi = 0; gi < NOPS; gi++) begin : g_op
      fmac_opsel #(.DW(DW)) u_sel (
         .sel_i (sel[gi]),
         .prim_i(prim[gi]),
         .data_i(data_i),
         .accw_i(acc_i[2*DW-1:DW]),
         .sgn_i (sgn[gi]),
         .op_o  (op[gi])
      );
   end

   fmac_mode_t    mode;
   logic [AW-1:0] res_d;
   logic          zero_d, ovf_d;

   assign mode = '{frac: frac_i, rnd: rnd_i, sat: sat_i};

   fmac_core #(.DW(DW), .AW(AW), .SAT_W(SAT_W)) u_core (
      .x_i   (op[0]),
      .y_i   (op[1]),
      .acc_i (acc_i),
      .mode_i(mode),
      .res_o (res_d),
      .zero_o(zero_d),
      .ovf_o (ovf_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q    <= '0;
         res_o  <= '0;
         zero_o <= 1'b1;
         ovf_o  <= 1'b0;
      end else begin
         if (tld_i) t_q <= tdin_i;
         res_o  <= res_d;
         zero_o <= zero_d;
         ovf_o  <= ovf_d;
      end
   end
endmodule

// File: rtl/fmac_chk.sv
module fmac_chk #(
   parameter int DW    = 16,
   parameter int AW    = 40,
   parameter int SAT_W = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tld_i,
   input logic [DW-1:0] tdin_i,
   input logic          rnd_i,
   input logic          sat_i,
   input logic [DW-1:0] t_q,
   input logic [AW-1:0] res_o,
   input logic          zero_o,
   input logic          ovf_o
);
   localparam logic [AW-1:0] POS_LIM = {{(AW-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
   localparam logic [AW-1:0] NEG_LIM = {{(AW-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

   logic past_ok;
   logic in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign in_range = (&res_o[AW-1:SAT_W-1]) || !(|res_o[AW-1:SAT_W-1]);

   p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      zero_o == (res_o == '0));

   p_round_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(rnd_i) && !($past(sat_i) && ovf_o) |-> res_o[DW-1:0] == '0);

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !ovf_o |-> in_range);

   p_sat_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(sat_i) |-> in_range);

   p_sat_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(sat_i) && ovf_o |-> (res_o == POS_LIM || res_o == NEG_LIM));

   p_t_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(tld_i) |-> t_q == $past(tdin_i));

   p_t_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(tld_i) |-> $stable(t_q));
endmodule

bind fmac_unit fmac_chk #(.DW(DW), .AW(AW), .SAT_W(SAT_W)) u_fmac_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .tld_i (tld_i),
   .tdin_i(tdin_i),
   .rnd_i (rnd_i),
   .sat_i (sat_i),
   .t_q   (t_q),
   .res_o (res_o),
   .zero_o(zero_o),
   .ovf_o (ovf_o)
);

// File: tb/tb_fmac_unit.sv
module tb_fmac_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tld_i = 1'b0;
   logic [15:0] tdin_i = '0, data_i = '0, prog_i = '0;
   logic [39:0] acc_i = '0;
   logic [1:0]  xsel_i = '0, ysel_i = '0;
   logic        xsgn_i = 1'b0, ysgn_i = 1'b0;
   logic        frac_i = 1'b0, rnd_i = 1'b0, sat_i = 1'b0;
   logic [39:0] res_o;
   logic        zero_o, ovf_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   fmac_unit dut (.*);

   typedef struct {
      logic [39:0] res;
      logic        zero;
      logic        ovf;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0;
   int          errors = 0;
   logic [15:0] model_t = '0;
   bit          done = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [39:0] act, input logic [39:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] pick(input logic [1:0] s, input logic [15:0] prim,
                                        input logic [15:0] dat, input logic [39:0] acc);
      if (s == 2'd0) return prim;
      if (s == 2'd1) return dat;
      return acc[31:16];
   endfunction

   function automatic longint widen(input logic [15:0] v, input bit sg);
      if (sg) return longint'(signed'(v));
      return longint'({48'b0, v});
   endfunction

   task automatic do_op(input logic [1:0] xs, input logic [1:0] ys,
                        input bit xsg, input bit ysg,
                        input bit fr, input bit rn, input bit st,
                        input logic [15:0] dat, input logic [15:0] prg,
                        input logic [39:0] acc, input bit tl,
                        input logic [15:0] td, input string tag);
      longint p, s;
      exp_t   e;
      @(negedge clk);
      xsel_i = xs; ysel_i = ys; xsgn_i = xsg; ysgn_i = ysg;
      frac_i = fr; rnd_i = rn; sat_i = st;
      data_i = dat; prog_i = prg; acc_i = acc; tld_i = tl; tdin_i = td;
      p = widen(pick(xs, model_t, dat, acc), xsg) * widen(pick(ys, prg, dat, acc), ysg);
      if (fr) p = p * 2;
      s = longint'(signed'(acc)) + p;
      if (rn) s = (s + 32768) & ~longint'(65535);
      e.ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      if (st && e.ovf) e.res = (s < 0) ? 40'hFF80000000 : 40'h007FFFFFFF;
      else             e.res = s[39:0];
      e.zero = (e.res == '0);
      e.tag  = tag;
      sb.push_back(e);
      if (tl) model_t = td;
   endtask

   // monitor: result of the operation driven before this edge
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(res_o == e.res, e.tag, "res", res_o, e.res);
         check(zero_o == e.zero, "R6", {e.tag, " zero"}, 40'(zero_o), 40'(e.zero));
         check(ovf_o == e.ovf, "R7", {e.tag, " ovf"}, 40'(ovf_o), 40'(e.ovf));
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(res_o == '0, "R10", "res in reset", res_o, '0);
      check(zero_o == 1'b1, "R10", "zero in reset", 40'(zero_o), 40'd1);
      check(ovf_o == 1'b0, "R10", "ovf in reset", 40'(ovf_o), 40'd0);
      rst_n = 1'b1;
      // R10: T is 0 after reset -> T*prog adds nothing
      do_op(2'd0, 2'd0, 1, 1, 0, 0, 0, 16'h0, 16'h1234, 40'd55, 0, 16'h0, "R10 treg");
      // R9: load T=3; this op still sees old T (0)
      do_op(2'd0, 2'd0, 1, 1, 0, 0, 0, 16'h0, 16'h0007, 40'd10, 1, 16'd3, "R9 load cycle");
      // R1/R3: T*prog signed: 100 + 3*(-2) = 94
      do_op(2'd0, 2'd0, 1, 1, 0, 0, 0, 16'h0, 16'hFFFE, 40'd100, 0, 16'h0, "R1 t*prog");
      // R2 unsigned 0xFFFF*0xFFFF
      do_op(2'd1, 2'd1, 0, 0, 0, 0, 0, 16'hFFFF, 16'h0, 40'd0, 0, 16'h0, "R2 unsigned");
      // R2 signed -1*-1 = 1
      do_op(2'd1, 2'd1, 1, 1, 0, 0, 0, 16'hFFFF, 16'h0, 40'd0, 0, 16'h0, "R2 signed");
      // R2 mixed: signed -1 * unsigned 0xFFFF
      do_op(2'd1, 2'd1, 1, 0, 0, 0, 0, 16'hFFFF, 16'h0, 40'd0, 0, 16'h0, "R2 mixed");
      // R3 accumulator word as both operands, codes 2 and 3
      do_op(2'd2, 2'd3, 1, 1, 0, 0, 0, 16'h0, 16'h0, 40'h00_0005_0000, 0, 16'h0, "R3 acc word");
      do_op(2'd3, 2'd2, 1, 1, 0, 0, 0, 16'h0, 16'h0, 40'h00_FFFD_0001, 0, 16'h0, "R3 acc word neg");
      // R3 data as X, prog as Y
      do_op(2'd1, 2'd0, 1, 1, 0, 0, 0, 16'd7, 16'd9, 40'd1, 0, 16'h0, "R3 data*prog");
      // R4 fractional 0.5*0.5
      do_op(2'd1, 2'd0, 1, 1, 1, 0, 0, 16'h4000, 16'h4000, 40'd0, 0, 16'h0, "R4 frac");
      // R5 rounding up and down
      do_op(2'd1, 2'd1, 1, 1, 0, 1, 0, 16'h0, 16'h0, 40'h00_0001_8000, 0, 16'h0, "R5 round up");
      do_op(2'd1, 2'd1, 1, 1, 0, 1, 0, 16'h0, 16'h0, 40'h00_0001_7FFF, 0, 16'h0, "R5 round down");
      do_op(2'd1, 2'd1, 1, 1, 0, 1, 0, 16'h0, 16'h0, 40'hFF_FFFF_7FFF, 0, 16'h0, "R5 round neg");
      // R6 zero result
      do_op(2'd1, 2'd0, 1, 1, 0, 0, 0, 16'd3, 16'd2, -40'sd6, 0, 16'h0, "R6 zero");
      // R7 overflow kept without saturation
      do_op(2'd1, 2'd1, 1, 1, 0, 0, 0, 16'd1, 16'h0, 40'h00_7FFF_FFFF, 0, 16'h0, "R7 ovf wrap");
      // R8 saturation positive and negative
      do_op(2'd1, 2'd1, 1, 1, 0, 0, 1, 16'd1, 16'h0, 40'h00_7FFF_FFFF, 0, 16'h0, "R8 sat pos");
      do_op(2'd1, 2'd0, 1, 1, 0, 0, 1, 16'hFFFF, 16'd1, 40'hFF_8000_0000, 0, 16'h0, "R8 sat neg");
      do_op(2'd1, 2'd1, 1, 1, 0, 0, 1, 16'h0, 16'h0, 40'h7F_0000_0000, 0, 16'h0, "R8 sat guard");
      // R8 boundary: exactly at limit, no overflow
      do_op(2'd1, 2'd1, 1, 1, 0, 0, 1, 16'h0, 16'h0, 40'h00_7FFF_FFFF, 0, 16'h0, "R8 at limit");
      // rounding pushes into saturation in the same cycle
      do_op(2'd1, 2'd1, 1, 1, 0, 1, 1, 16'h0, 16'h0, 40'h00_7FFF_8000, 0, 16'h0, "R8 round+sat");
      // fractional doubling into negative saturation
      do_op(2'd1, 2'd0, 1, 1, 1, 0, 1, 16'h8000, 16'h7FFF, 40'hFF_C000_0000, 0, 16'h0, "R4 frac+sat");
      // pseudo-random mix
      lf = 32'hACE1_2345;
      for (int i = 0; i < 80; i++) begin
         logic [39:0] a;
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         a = {lf[7:0], lf};
         if (lf[30]) a = {{8{lf[31]}}, lf};
         do_op(lf[1:0], lf[3:2], lf[4], lf[5], lf[6], lf[7], lf[8],
               lf[31:16] ^ 16'h5A5A, lf[23:8], a, lf[9], lf[27:12], "R1 random");
      end
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule